// File: doc/BRIEF.md
# Embedded sync timing decoder

This block recovers line and field timing from an 8-bit, 4:2:2 multiplexed standard-definition byte stream. The stream carries one byte per clock when the clock enable is high. No separate sync wires are used. Every line is framed by two four-byte timing codes: one marks where the picture samples stop and the other marks where they start again. Each code is three fixed lead bytes followed by a status byte. The status byte carries the field, vertical-blank and horizontal-position bits, plus four protection bits.

The decoder tracks these codes and drives registered horizontal-blank, vertical-blank and field flags. It marks each picture byte as active and reports its component (Cb, Y or Cr). It measures the gap between the two codes to tell 525-line from 625-line video. It also measures the picture run and reports any run of the wrong length. A status byte that fails its protection check raises a one-clock code error and leaves the timing flags as they were.

A typical use is as the front end of a video output path. The downstream logic takes its line structure from these flags and never has to parse the byte stream itself.

Top module: `sd_sync_decoder`

## Requirements
- R1: During and right after reset, h_blank=1, v_blank=1, field=0, active=0, comp=0, std_625=0, code_error=0 and len_error=0.
- R2: A status byte is recognised only when it follows the bytes 0xFF, 0x00, 0x00 in sequence. A 0xFF received at any point of the match restarts it, so FF FF 00 00 and FF 00 FF 00 00 both frame a status byte. A broken lead (for example FF 00 10 00) frames nothing.
- R3: In the status byte, bit 6 is the field bit, bit 5 is the vertical-blank bit and bit 4 is H (1 = end of picture, 0 = start of picture). One clock after an accepted status byte, field, v_blank and h_blank equal those bits.
- R4: A status byte is accepted only if bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}. Otherwise code_error is high in the following cycle, and field, v_blank and h_blank keep their values.
- R5: The gap is the number of bytes between an accepted end code's status byte and the first 0xFF of the next accepted start code. A gap of 280 sets std_625 and a gap of 268 clears it. The flag is updated one clock after the start code's status byte and changes at no other time.
- R6: Any other gap raises len_error for one clock after that start code's status byte, and std_625 does not change. This check is skipped until an end code has been accepted since reset, and it is skipped when the start code arrives while h_blank is 0.
- R7: If an accepted end code arrives while h_blank is 0, there must be exactly 1440 bytes between the start code's status byte and the end code's first 0xFF. Any other count raises len_error for one clock after the end code's status byte.
- R8: After an accepted start code with V=0, the first 1440 accepted bytes each raise active one clock later. comp gives the byte's component in the order Cb, Y, Cr, Y, encoded as 01, 10, 11, 10. All other bytes give active=0 and comp=00, and so does every byte of a line whose start code had V=1.
- R9: While ce is 0, the input byte is ignored. h_blank, v_blank, field, active, comp and std_625 hold, and code_error and len_error are 0.
- R10: code_error and len_error are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Byte enable; din is taken only when high |
| din | input | 8 | Multiplexed video byte |
| h_blank | output | 1 | Horizontal blanking flag |
| v_blank | output | 1 | Vertical blanking flag |
| field | output | 1 | Field flag |
| active | output | 1 | The byte taken last is a picture sample |
| comp | output | 2 | Component of that byte: 00 none, 01 Cb, 10 Y, 11 Cr |
| std_625 | output | 1 | 1 = 625-line gap measured, 0 = 525-line |
| code_error | output | 1 | One-clock pulse for a status byte that fails its check |
| len_error | output | 1 | One-clock pulse for a wrong gap or picture length |

## Verification
Every output is registered once past the byte that causes it, so each result is due exactly one clock after the edge that takes that byte. This holds for flags, active and comp, std_625 and both error pulses. The bench drives each byte on a falling edge and compares all outputs 1 ns after the next rising edge, against a model that it advances from the requirements byte by byte. Idle cycles with ce low are checked in the same way: each must leave the held outputs unchanged and both pulses low.

// File: rtl/sd_sync_pkg.sv
// Shared types and helpers for the embedded sync timing decoder.
// Assumes status bytes use bit 7 as a marker and bits 3..0 as protection.
package sd_sync_pkg;

    typedef enum logic [1:0] {
        COMP_NONE = 2'b00,
        COMP_CB   = 2'b01,
        COMP_Y    = 2'b10,
        COMP_CR   = 2'b11
    } comp_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tflags_t;

    localparam logic [7:0] LEAD_BYTE = 8'hFF;
    localparam logic [7:0] ZERO_BYTE = 8'h00;
    localparam int         CODE_TAIL = 3;

    // True when the status byte has its marker bit and consistent protection bits.
    function automatic logic status_ok(input logic [7:0] xy);
        logic f, v, h;
        f = xy[6];
        v = xy[5];
        h = xy[4];
        return xy[7] && (xy[3:0] == {v ^ h, f ^ h, f ^ v, f ^ v ^ h});
    endfunction

    // Component type for a picture byte at a given position within its group of four.
    function automatic comp_e comp_of(input logic [1:0] pos);
        case (pos)
            2'd0:    return COMP_CB;
            2'd2:    return COMP_CR;
            default: return COMP_Y;
        endcase
    endfunction

endpackage

// File: rtl/sd_code_matcher.sv
// Lead-sequence matcher: finds FF 00 00 in the accepted byte stream and
// strobes the byte that follows as a status byte.
// Assumes bytes count only when ce is high; a 0xFF always restarts the match.
module sd_code_matcher
    import sd_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic [7:0] din,
    output logic       code_stb
);

    typedef enum logic [1:0] {M_IDLE, M_LEAD, M_ZERO1, M_ZERO2} mstate_e;

    mstate_e st;

    // Advance the lead-sequence match on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= M_IDLE;
        end else if (ce) begin
            if (din == LEAD_BYTE) begin
                st <= M_LEAD;
            end else begin
                case (st)
                    M_LEAD:  st <= (din == ZERO_BYTE) ? M_ZERO1 : M_IDLE;
                    M_ZERO1: st <= (din == ZERO_BYTE) ? M_ZERO2 : M_IDLE;
                    default: st <= M_IDLE;
                endcase
            end
        end
    end

    // The byte after the two zeros is the status byte.
    always_comb code_stb = ce && (st == M_ZERO2);

    // R2: once a status byte is taken, the match cannot still sit in a zero state.
    assert_match_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        code_stb |=> (st == M_IDLE || st == M_LEAD));

endmodule

// File: rtl/sd_xy_check.sv
// Status-byte checker: validates the framed status byte and holds the
// field, vertical-blank and horizontal flags; pulses an error on a bad byte.
// Assumes code_stb is already qualified by the byte enable.
module sd_xy_check
    import sd_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       code_stb,
    input  logic [7:0] xy,
    output tflags_t    flags,
    output logic       code_error,
    output logic       upd_eav,
    output logic       upd_sav
);

    logic good;

    // Classify the framed status byte.
    always_comb begin
        good    = status_ok(xy);
        upd_eav = code_stb && good && xy[4];
        upd_sav = code_stb && good && !xy[4];
    end

    // Hold the timing flags and raise the one-clock error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags      <= '{f: 1'b0, v: 1'b1, h: 1'b1};
            code_error <= 1'b0;
        end else begin
            code_error <= code_stb && !good;
            if (code_stb && good) begin
                flags <= '{f: xy[6], v: xy[5], h: xy[4]};
            end
        end
    end

    assert_flags_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb && good) |=> (flags == $past(xy[6:4])));

    assert_bad_code_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb && !good) |=> (code_error && $stable(flags)));

    assert_code_error_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        code_error |=> !code_error);

    assert_idle_holds_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(flags) && !code_error));

endmodule

// File: rtl/sd_line_timer.sv
// Line timer: counts bytes since the last accepted code, judges the gap
// and picture lengths, keeps the line standard flag and tags picture bytes.
// Assumes upd_eav/upd_sav are single-cycle pulses on accepted status bytes.
module sd_line_timer
    import sd_sync_pkg::*;
#(
    parameter int ACTIVE_LEN = 1440,
    parameter int GAP_525    = 268,
    parameter int GAP_625    = 280
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce,
    input  logic  upd_eav,
    input  logic  upd_sav,
    input  logic  h_blank,
    input  logic  v_blank,
    output logic  std_625,
    output logic  len_error,
    output logic  active,
    output comp_e comp
);

    localparam int LONGEST = (ACTIVE_LEN > GAP_625 ? ACTIVE_LEN : GAP_625) + CODE_TAIL + 1;
    localparam int CNT_W   = $clog2(LONGEST + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ACT_END  = CNT_W'(ACTIVE_LEN + CODE_TAIL);
    localparam logic [CNT_W-1:0] ACT_LIM  = CNT_W'(ACTIVE_LEN);
    localparam logic [CNT_W-1:0] END_525  = CNT_W'(GAP_525 + CODE_TAIL);
    localparam logic [CNT_W-1:0] END_625  = CNT_W'(GAP_625 + CODE_TAIL);

    logic [CNT_W-1:0] run;
    logic             ref_ok;
    logic             gap_check;
    logic             act_check;
    logic             code_upd;

    // Decide which length check applies to this accepted code.
    always_comb begin
        code_upd  = upd_eav || upd_sav;
        gap_check = upd_sav && h_blank && ref_ok;
        act_check = upd_eav && !h_blank;
    end

    // Count accepted bytes since the last accepted code, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (code_upd) begin
            run <= '0;
        end else if (ce && run != CNT_MAX) begin
            run <= run + 1'b1;
        end
    end

    // Remember that a gap measurement has a valid starting point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_ok <= 1'b0;
        end else if (upd_eav) begin
            ref_ok <= 1'b1;
        end
    end

    // Judge lengths and keep the line standard flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_625   <= 1'b0;
            len_error <= 1'b0;
        end else begin
            len_error <= (act_check && run != ACT_END) ||
                         (gap_check && run != END_525 && run != END_625);
            if (gap_check && run == END_625) begin
                std_625 <= 1'b1;
            end else if (gap_check && run == END_525) begin
                std_625 <= 1'b0;
            end
        end
    end

    // Tag each accepted byte as picture sample or not, with its component.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            comp   <= COMP_NONE;
        end else if (ce) begin
            if (!code_upd && !h_blank && !v_blank && run < ACT_LIM) begin
                active <= 1'b1;
                comp   <= comp_of(run[1:0]);
            end else begin
                active <= 1'b0;
                comp   <= COMP_NONE;
            end
        end
    end

    assert_std_only_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(std_625) |-> $past(upd_sav));

    assert_len_error_on_code_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        len_error |-> $past(code_upd));

    assert_len_error_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        len_error |=> !len_error);

    assert_active_in_picture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (!h_blank && !v_blank && comp != COMP_NONE));

    assert_idle_holds_tags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(active) && $stable(comp) && $stable(std_625) && !len_error));

endmodule

// File: rtl/sd_sync_decoder.sv
// Embedded sync timing decoder top: ties the lead matcher, status checker
// and line timer together and drives plain output ports.
// Assumes one byte per clock when ce is high; no external sync inputs.
module sd_sync_decoder
    import sd_sync_pkg::*;
#(
    parameter int ACTIVE_LEN = 1440,
    parameter int GAP_525    = 268,
    parameter int GAP_625    = 280
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic [7:0] din,
    output logic       h_blank,
    output logic       v_blank,
    output logic       field,
    output logic       active,
    output logic [1:0] comp,
    output logic       std_625,
    output logic       code_error,
    output logic       len_error
);

    logic    code_stb;
    logic    upd_eav;
    logic    upd_sav;
    tflags_t flags;
    comp_e   comp_w;

    sd_code_matcher u_matcher (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .din      (din),
        .code_stb (code_stb)
    );

    sd_xy_check u_xy (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce),
        .code_stb   (code_stb),
        .xy         (din),
        .flags      (flags),
        .code_error (code_error),
        .upd_eav    (upd_eav),
        .upd_sav    (upd_sav)
    );

    sd_line_timer #(
        .ACTIVE_LEN (ACTIVE_LEN),
        .GAP_525    (GAP_525),
        .GAP_625    (GAP_625)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .upd_eav   (upd_eav),
        .upd_sav   (upd_sav),
        .h_blank   (flags.h),
        .v_blank   (flags.v),
        .std_625   (std_625),
        .len_error (len_error),
        .active    (active),
        .comp      (comp_w)
    );

    // Expose the held flags and the component tag as plain ports.
    always_comb begin
        h_blank = flags.h;
        v_blank = flags.v;
        field   = flags.f;
        comp    = comp_w;
    end

endmodule

// File: tb/sd_sync_decoder_bench.sv
// Self-checking bench: walks a table of lines, then directed reset and
// lead-sequence cases, comparing every output one clock after each byte.
module sd_sync_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic [7:0] din = 8'h00;
    logic       h_blank, v_blank, field, active, std_625, code_error, len_error;
    logic [1:0] comp;

    always #5 clk = ~clk;

    sd_sync_decoder u_sd_sync_decoder (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
        .h_blank(h_blank), .v_blank(v_blank), .field(field), .active(active),
        .comp(comp), .std_625(std_625), .code_error(code_error), .len_error(len_error)
    );

    typedef struct packed {
        logic        f;
        logic        v;
        logic [1:0]  bad;       // 0 none, 1 end code protection flipped, 2 start code marker cleared
        logic        gap;       // idle cycle before every byte
        logic [10:0] blank;
        logic [10:0] act;
        logic        exp_std;
        logic        exp_gap_err;
    } line_t;

    localparam int NLINES = 10;
    localparam line_t LINES [NLINES] = '{
        '{1'b0, 1'b0, 2'd0, 1'b0, 11'd268, 11'd1440, 1'b0, 1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b1, 11'd280, 11'd1440, 1'b1, 1'b0},
        '{1'b1, 1'b1, 2'd0, 1'b0, 11'd280, 11'd1440, 1'b1, 1'b0},
        '{1'b1, 1'b0, 2'd0, 1'b0, 11'd275, 11'd1440, 1'b1, 1'b1},
        '{1'b0, 1'b0, 2'd0, 1'b0, 11'd280, 11'd1000, 1'b1, 1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b0, 11'd280, 11'd1440, 1'b1, 1'b0},
        '{1'b0, 1'b0, 2'd1, 1'b0, 11'd268, 11'd1440, 1'b1, 1'b0},
        '{1'b0, 1'b0, 2'd2, 1'b0, 11'd268, 11'd1440, 1'b1, 1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b0, 11'd268, 11'd1440, 1'b0, 1'b0},
        '{1'b1, 1'b0, 2'd0, 1'b0, 11'd280, 11'd1440, 1'b1, 1'b0}
    };

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Requirement-level model state.
    bit m_h, m_v, m_f, m_std, m_eav;
    int m_run;
    bit last_lerr;

    function automatic logic [7:0] mk_xy(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic bit xy_good(input logic [7:0] x);
        logic [7:0] ref_xy;
        ref_xy = mk_xy(x[6], x[5], x[4]);
        return x[7] && (x[3:0] == ref_xy[3:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_h = 1'b1; m_v = 1'b1; m_f = 1'b0; m_std = 1'b0; m_eav = 1'b0; m_run = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ce = 1'b0; din = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk({h_blank, v_blank, field, active, comp, std_625, code_error, len_error} == 9'b110000000,
            "R1 reset state", {h_blank, v_blank, field, active, comp, std_625, code_error, len_error}, 9'b110000000);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Drive one byte (optionally after an idle cycle) and check every output one clock later.
    task automatic push(input logic [7:0] b, input bit is_code, input bit gap);
        bit e_cerr, e_lerr, e_act, good;
        int e_comp;
        string ltag;
        logic [6:0] snap;
        if (gap) begin
            @(negedge clk);
            ce = 1'b0; din = 8'hFF;
            snap = {h_blank, v_blank, field, active, comp, std_625};
            @(posedge clk); #1;
            chk({h_blank, v_blank, field, active, comp, std_625} == snap, "R9 idle hold",
                {h_blank, v_blank, field, active, comp, std_625}, snap);
            chk(!code_error && !len_error, "R9 idle pulses", {code_error, len_error}, 0);
        end
        @(negedge clk);
        ce = 1'b1; din = b;
        @(posedge clk); #1;
        e_cerr = 1'b0; e_lerr = 1'b0; e_act = 1'b0; e_comp = 0; ltag = "R6 no error";
        good = is_code && xy_good(b);
        if (is_code && !good) e_cerr = 1'b1;
        if (good) begin
            if (b[4]) begin
                ltag = "R7 picture length";
                if (!m_h && m_run != 1443) e_lerr = 1'b1;
                m_eav = 1'b1;
            end else begin
                ltag = "R6 gap length";
                if (m_h && m_eav) begin
                    if (m_run == 283) m_std = 1'b1;
                    else if (m_run == 271) m_std = 1'b0;
                    else e_lerr = 1'b1;
                end
            end
            m_f = b[6]; m_v = b[5]; m_h = b[4]; m_run = 0;
        end else begin
            e_act = !m_h && !m_v && (m_run < 1440);
            if (e_act) begin
                case (m_run % 4)
                    0: e_comp = 1;
                    2: e_comp = 3;
                    default: e_comp = 2;
                endcase
            end
            m_run++;
        end
        last_lerr = len_error;
        chk({field, v_blank, h_blank} == {m_f, m_v, m_h}, "R3 flags", {field, v_blank, h_blank}, {m_f, m_v, m_h});
        chk(active == e_act && comp == 2'(e_comp), "R8 active/comp", {active, comp}, {e_act, 2'(e_comp)});
        chk(code_error == e_cerr, "R4 code_error", code_error, e_cerr);
        chk(len_error == e_lerr, ltag, len_error, e_lerr);
        chk(std_625 == m_std, "R5 std_625", std_625, m_std);
    endtask

    task automatic push_code(input logic [7:0] xy, input bit gap);
        push(8'hFF, 1'b0, gap);
        push(8'h00, 1'b0, gap);
        push(8'h00, 1'b0, gap);
        push(xy, 1'b1, gap);
    endtask

    task automatic send_line(input line_t ln);
        logic [7:0] xe, xs;
        bit gap_err;
        xe = mk_xy(ln.f, ln.v, 1'b1);
        xs = mk_xy(ln.f, ln.v, 1'b0);
        if (ln.bad == 2'd1) xe = xe ^ 8'h01;
        if (ln.bad == 2'd2) xs = xs & 8'h7F;
        push_code(xe, ln.gap);
        for (int i = 0; i < int'(ln.blank); i++) push((i % 2 == 0) ? 8'h80 : 8'h10, 1'b0, ln.gap);
        push_code(xs, ln.gap);
        gap_err = last_lerr;
        // Table expectations for the start code of this line (R5, R6).
        chk(std_625 == ln.exp_std, "R5 table std_625", std_625, ln.exp_std);
        chk(gap_err == ln.exp_gap_err, "R6 table gap error", gap_err, ln.exp_gap_err);
        for (int i = 0; i < int'(ln.act); i++) push((i % 2 == 0) ? 8'h80 : 8'h50, 1'b0, ln.gap);
    endtask

    initial begin
        model_reset();
        last_lerr = 1'b0;
        do_reset();
        for (int k = 0; k < NLINES; k++) send_line(LINES[k]);

        // R2: doubled lead byte still frames a valid end code.
        push(8'hFF, 1'b0, 1'b0);
        push_code(mk_xy(1'b0, 1'b1, 1'b1), 1'b0);
        chk(h_blank && v_blank, "R2 restart on doubled lead", {h_blank, v_blank}, 2'b11);
        for (int i = 0; i < 268; i++) push(8'h80, 1'b0, 1'b0);
        // R2: lead restarted after one zero.
        push(8'hFF, 1'b0, 1'b0);
        push(8'h00, 1'b0, 1'b0);
        push_code(mk_xy(1'b1, 1'b0, 1'b0), 1'b0);
        chk(!h_blank && field, "R2 restart after partial lead", {h_blank, field}, 2'b01);
        // R2: broken lead frames nothing; flags must not move.
        push(8'hFF, 1'b0, 1'b0);
        push(8'h00, 1'b0, 1'b0);
        push(8'h10, 1'b0, 1'b0);
        push(8'h00, 1'b0, 1'b0);
        push(mk_xy(1'b0, 1'b1, 1'b1), 1'b0, 1'b0);
        chk(!h_blank && !v_blank, "R2 broken lead ignored", {h_blank, v_blank}, 2'b00);

        // R6: after reset, no gap check until an end code is seen.
        do_reset();
        for (int i = 0; i < 100; i++) push(8'h10, 1'b0, 1'b0);
        push_code(mk_xy(1'b0, 1'b0, 1'b0), 1'b0);
        chk(!last_lerr && !std_625, "R6 no check before first end code", {last_lerr, std_625}, 0);
        for (int i = 0; i < 8; i++) push(8'h80, 1'b0, 1'b0);

        @(negedge clk);
        ce = 1'b0;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule